// File: doc/BRIEF.md
# MII Transmit 4B/5B Symbol Encoder

This block sits on the PHY side of a 100 Mb/s link, between the MAC's media-independent transmit interface and the line-side coding stages. On every transmit clock edge it samples a frame-enable strobe, an error strobe and one data nibble. It then produces one 5-bit code group. Between frames it sends the IDLE code group without a break. When a frame starts, the first two nibbles are replaced by the J and K start delimiters. Later nibbles pass through the standard 4B/5B data table. When the enable strobe drops, the block closes the frame with the T and R end delimiters.

While a frame is active, any cycle in which the MAC raises the error strobe sends the HALT code group in place of that slot's symbol. This corrupts the frame on purpose, so the far-end PHY discards it. Scrambling, serialization and the receive path belong to other blocks.

A four-state machine controls the framing:
- IDLE waits for the enable strobe.
- SSD2 emits the second start delimiter.
- DATA carries the payload.
- ESD2 emits the second end delimiter.

The transitions are:
- START: IDLE to SSD2, when the enable strobe is high in IDLE.
- BEGIN_DATA: SSD2 to DATA, when the enable strobe stays high.
- SHORT_END: SSD2 to ESD2, when the enable strobe falls in the K slot.
- END: DATA to ESD2, when the enable strobe falls.
- RESUME: ESD2 to IDLE, always taken.

IDLE and DATA also hold their own state while their inputs do not change. Every code group is registered, so the symbol for the inputs sampled at one clock edge appears just after that same edge.

Top module: `mii_tx_encoder`

## Requirements
- R1: While reset is asserted, and after it is released until a frame starts, `code_o` is the IDLE code group 11111.
- R2: While no frame is active and `tx_en` is low, `code_o` stays 11111 whatever `txd` and `tx_er` carry.
- R3: The first cycle with `tx_en` high after IDLE emits J (11000). The second cycle emits K (10001), provided `tx_en` is still high.
- R4: Every later nibble sampled with `tx_en` high and `tx_er` low is encoded as follows (nibble:code): 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101.
- R5: The first cycle with `tx_en` low after data emits T (01101). The next cycle emits R (00111). IDLE (11111) follows until the next frame.
- R6: Each cycle sampled with both `tx_en` and `tx_er` high, in the J, K or data slot, emits HALT (00100) instead of that slot's code. The frame continues afterwards, for any number of consecutive error cycles.
- R7: The code group for the inputs sampled at clock edge k is visible on `code_o` right after edge k and is held until edge k+1.
- R8: A frame whose `tx_en` is high for a single cycle emits J, then T, then R.
- R9: In the R slot, `tx_en`, `tx_er` and `txd` have no effect and R is emitted. A `tx_en` still high in the following cycle starts a new frame with J.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock, one nibble per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Frame enable from the MAC |
| tx_er | input | 1 | Transmit error strobe from the MAC |
| txd | input | 4 | Transmit data nibble |
| code_o | output | 5 | Registered 5-bit code group toward the line |

## Verification
The hardest situation to reach is the boundary where one frame ends and the next begins: `tx_en` is low for exactly one cycle and then high again during the R slot. The block must ignore it there and begin J one cycle later. A second hard case is an error strobe that lands on a delimiter slot rather than a payload slot. The stimulus reaches both with directed frames. These include a back-to-back pair separated by a single low cycle, a frame with `tx_en` held high through R, a one-nibble frame, and frames with error bursts placed on the J slot, the K slot and several consecutive data slots.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;

    localparam int NIB_W  = 4;
    localparam int CODE_W = 5;

    typedef logic [NIB_W-1:0]  nibble_t;
    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CG_IDLE = 5'b11111;
    localparam code_t CG_J    = 5'b11000;
    localparam code_t CG_K    = 5'b10001;
    localparam code_t CG_T    = 5'b01101;
    localparam code_t CG_R    = 5'b00111;
    localparam code_t CG_HALT = 5'b00100;

    // Framing states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SSD2 = 2'd1,
        ST_DATA = 2'd2,
        ST_ESD2 = 2'd3
    } tx_state_e;

    // Which symbol the output stage loads this cycle
    typedef enum logic [2:0] {
        SEL_IDLE = 3'd0,
        SEL_J    = 3'd1,
        SEL_K    = 3'd2,
        SEL_DATA = 3'd3,
        SEL_T    = 3'd4,
        SEL_R    = 3'd5,
        SEL_HALT = 3'd6
    } sym_sel_e;

endpackage

// File: rtl/mii_tx_nibble_enc.sv
module mii_tx_nibble_enc
    import mii_tx_pkg::*;
(
    input  nibble_t nib_i,
    output code_t   code_o
);

    always_comb begin
        unique case (nib_i)
            4'h0:    code_o = 5'b11110;
            4'h1:    code_o = 5'b01001;
            4'h2:    code_o = 5'b10100;
            4'h3:    code_o = 5'b10101;
            4'h4:    code_o = 5'b01010;
            4'h5:    code_o = 5'b01011;
            4'h6:    code_o = 5'b01110;
            4'h7:    code_o = 5'b01111;
            4'h8:    code_o = 5'b10010;
            4'h9:    code_o = 5'b10011;
            4'hA:    code_o = 5'b10110;
            4'hB:    code_o = 5'b10111;
            4'hC:    code_o = 5'b11010;
            4'hD:    code_o = 5'b11011;
            4'hE:    code_o = 5'b11100;
            default: code_o = 5'b11101;
        endcase
    end

endmodule

// File: rtl/mii_tx_fsm.sv
module mii_tx_fsm
    import mii_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tx_en,
    input  logic      tx_er,
    output tx_state_e state_o,
    output sym_sel_e  sel_o
);

    tx_state_e state_q;
    tx_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (tx_en) state_d = ST_SSD2;             // START
            ST_SSD2: state_d = tx_en ? ST_DATA : ST_ESD2;       // BEGIN_DATA / SHORT_END
            ST_DATA: if (!tx_en) state_d = ST_ESD2;             // END
            ST_ESD2: state_d = ST_IDLE;                         // RESUME
            default: state_d = ST_IDLE;
        endcase
    end

    // Symbol selection for the slot being sampled
    always_comb begin
        sel_o = SEL_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_en) sel_o = tx_er ? SEL_HALT : SEL_J;
                else       sel_o = SEL_IDLE;
            end
            ST_SSD2: begin
                if (tx_en) sel_o = tx_er ? SEL_HALT : SEL_K;
                else       sel_o = SEL_T;
            end
            ST_DATA: begin
                if (tx_en) sel_o = tx_er ? SEL_HALT : SEL_DATA;
                else       sel_o = SEL_T;
            end
            ST_ESD2: sel_o = SEL_R;
            default: sel_o = SEL_IDLE;
        endcase
    end

    assign state_o = state_q;

    assert_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ESD2) |=> (state_q == ST_IDLE));

    assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && tx_en) |=> (state_q == ST_SSD2));

    assert_short_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SSD2 && !tx_en) |=> (state_q == ST_ESD2));

endmodule

// File: rtl/mii_tx_sym_reg.sv
module mii_tx_sym_reg
    import mii_tx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  sym_sel_e sel_i,
    input  code_t    data_code_i,
    output code_t    code_o
);

    code_t code_q;
    code_t code_d;

    always_comb begin
        unique case (sel_i)
            SEL_IDLE: code_d = CG_IDLE;
            SEL_J:    code_d = CG_J;
            SEL_K:    code_d = CG_K;
            SEL_DATA: code_d = data_code_i;
            SEL_T:    code_d = CG_T;
            SEL_R:    code_d = CG_R;
            SEL_HALT: code_d = CG_HALT;
            default:  code_d = CG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= CG_IDLE;
        else        code_q <= code_d;
    end

    assign code_o = code_q;

endmodule

// File: rtl/mii_tx_encoder.sv
module mii_tx_encoder
    import mii_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              tx_er,
    input  logic [NIB_W-1:0]  txd,
    output logic [CODE_W-1:0] code_o
);

    tx_state_e state;
    sym_sel_e  sel;
    code_t     data_code;

    mii_tx_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_en   (tx_en),
        .tx_er   (tx_er),
        .state_o (state),
        .sel_o   (sel)
    );

    mii_tx_nibble_enc u_enc (
        .nib_i  (txd),
        .code_o (data_code)
    );

    mii_tx_sym_reg u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (sel),
        .data_code_i (data_code),
        .code_o      (code_o)
    );

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !tx_en) |=> (code_o == CG_IDLE));

    assert_j_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && tx_en && !tx_er) |=> (code_o == CG_J));

    assert_k_second_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SSD2 && tx_en && !tx_er) |=> (code_o == CG_K));

    assert_t_on_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && !tx_en) |=> (code_o == CG_T));

    assert_r_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ESD2) |=> (code_o == CG_R));

    assert_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && tx_er && state != ST_ESD2) |=> (code_o == CG_HALT));

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (code_o == CG_IDLE));

endmodule

// File: tb/mii_tx_encoder_bench.sv
module mii_tx_encoder_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       tx_er = 1'b0;
    logic [3:0] txd = 4'h0;
    logic [4:0] code_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [4:0] code;
        string      req;
    } exp_t;

    exp_t sb_q[$];

    localparam logic [4:0] E_IDLE = 5'b11111, E_J = 5'b11000, E_K = 5'b10001,
                           E_T = 5'b01101, E_R = 5'b00111, E_HALT = 5'b00100;
    localparam logic [4:0] TBL [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                                        5'b01010, 5'b01011, 5'b01110, 5'b01111,
                                        5'b10010, 5'b10011, 5'b10110, 5'b10111,
                                        5'b11010, 5'b11011, 5'b11100, 5'b11101};

    // Model position in the frame: 0 idle, 1 K slot, 2 data, 3 R slot
    int m_pos = 0;

    always #5 clk = ~clk;

    mii_tx_encoder u_mii_tx_encoder (
        .clk    (clk),
        .rst_n  (rst_n),
        .tx_en  (tx_en),
        .tx_er  (tx_er),
        .txd    (txd),
        .code_o (code_o)
    );

    task automatic check(input logic [4:0] act, input logic [4:0] exp, input string req);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: code_o=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: apply one cycle of inputs and push the expected code group
    task automatic drive(input logic en, input logic er, input logic [3:0] d);
        exp_t e;
        @(negedge clk);
        #1;
        tx_en = en; tx_er = er; txd = d;
        case (m_pos)
            0: begin
                if (en) begin
                    e.code = er ? E_HALT : E_J; e.req = er ? "R6" : "R3"; m_pos = 1;
                end else begin
                    e.code = E_IDLE; e.req = "R2";
                end
            end
            1: begin
                if (en) begin
                    e.code = er ? E_HALT : E_K; e.req = er ? "R6" : "R3"; m_pos = 2;
                end else begin
                    e.code = E_T; e.req = "R8"; m_pos = 3;
                end
            end
            2: begin
                if (en) begin
                    e.code = er ? E_HALT : TBL[d]; e.req = er ? "R6" : "R4";
                end else begin
                    e.code = E_T; e.req = "R5"; m_pos = 3;
                end
            end
            default: begin
                e.code = E_R; e.req = "R9"; m_pos = 0;
            end
        endcase
        sb_q.push_back(e);
    endtask

    // Monitor: compare away from the active edge, per R7 timing
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(code_o, e.code, e.req);
        end
    end

    task automatic send_frame(input int n, input int er_from, input int er_len);
        for (int i = 0; i < n; i++) begin
            logic er;
            er = (i >= er_from) && (i < er_from + er_len);
            drive(1'b1, er, (i < 7) ? 4'h5 : ((i == 7) ? 4'hD : 4'(i)));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(code_o, E_IDLE, "R1");
        #1; rst_n = 1'b1;
        @(negedge clk);
        check(code_o, E_IDLE, "R1");

        // R2: idle noise with tx_er and txd toggling, tx_en low
        for (int i = 0; i < 4; i++) drive(1'b0, i[0], 4'(i * 5));

        // R3/R4/R5: full frame covering all 16 nibble values
        send_frame(24, 99, 0);
        for (int i = 0; i < 3; i++) drive(1'b0, 1'b0, 4'hA);

        // R6: error on J slot, K slot, and a three-cycle data burst
        send_frame(14, 0, 2);
        drive(1'b0, 1'b1, 4'h3);
        drive(1'b0, 1'b0, 4'h0);
        send_frame(14, 9, 3);
        drive(1'b0, 1'b0, 4'h0);
        drive(1'b0, 1'b0, 4'h0);

        // R8: one-nibble frame
        drive(1'b1, 1'b0, 4'h5);
        drive(1'b0, 1'b0, 4'h0);
        drive(1'b0, 1'b0, 4'h0);
        drive(1'b0, 1'b0, 4'h0);

        // R9: back-to-back with tx_en high (and error) during the R slot
        send_frame(10, 99, 0);
        drive(1'b0, 1'b0, 4'h0);
        drive(1'b1, 1'b1, 4'hF);
        send_frame(10, 99, 0);
        drive(1'b0, 1'b0, 4'h0);
        drive(1'b0, 1'b0, 4'h0);
        drive(1'b0, 1'b0, 4'h0);

        wait (sb_q.size() == 0);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule